// File: doc/BRIEF.md
# Directory Invalidation Sequencer

This block holds the coherence state of a shared last-level cache slice that acts as the point of coherence. Each tracked line has a full-map sharer vector, with one bit per private cache. Beside that vector sits a second vector that marks which of those sharers hold the line in an instruction cache. Requests arrive from one ordered queue. The block takes one request at a time and finishes it before it accepts the next, so stores, atomics, loads, fetches and evictions take effect strictly in arrival order.

When a request accepts, the block works out which sharers must lose their copy. It sends them invalidations one per cycle, lowest sharer index first, and counts the acknowledgements still outstanding. The response is raised only when every invalidation has been sent and acknowledged. At that point the block writes the new sharer state back to the directory. The response carries the new sharer and instruction-holder vectors, so the surrounding cache can see the resulting state.

Top module: `dir_inval_seq`

## Requirements
- R1: After reset every line has empty sharer and instruction vectors, `req_ready` is 1, and `inv_valid` and `rsp_valid` are 0.
- R2: A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` stays low from that edge until the edge on which its response is taken, so no later request overtakes it.
- R3: Invalidations go out at most one per cycle, in strictly increasing sharer index order. `inv_line` equals the request's line, and each targeted sharer gets exactly one invalidation.
- R4: The response is not raised before every invalidation of the request has been acknowledged. `ack_valid` returns one acknowledgement per cycle.
- R5: Op code 2 (store or atomic) invalidates every sharer except the requester. Its result has only the requester's bit set and an all-zero instruction vector.
- R6: Op code 0 (data load) invalidates exactly the sharers whose instruction flag is set, the requester included. Its result is the old sharers minus the invalidated ones plus the requester. The instruction vector loses the invalidated bits.
- R7: Op code 1 (instruction fetch) sends no invalidation. It adds the requester to both the sharer vector and the instruction vector.
- R8: Op code 3 (eviction) invalidates every sharer and leaves both vectors of the line empty.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and every response field stays unchanged.
- R10: A request changes only the directory state of its own line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present at queue head |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 load, 1 fetch, 2 store/atomic, 3 evict |
| req_line | input | LINEW | Directory line index |
| req_src | input | IDXW | Requesting sharer index |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_dst | output | IDXW | Sharer being invalidated |
| inv_line | output | LINEW | Line being invalidated |
| ack_valid | input | 1 | One invalidation acknowledged |
| rsp_valid | output | 1 | Request complete |
| rsp_ready | input | 1 | Response taken |
| rsp_op | output | 2 | Op of completed request |
| rsp_line | output | LINEW | Line of completed request |
| rsp_src | output | IDXW | Requester of completed request |
| rsp_sharers | output | NUM_SHARERS | Sharer vector after the request |
| rsp_iflags | output | NUM_SHARERS | Instruction-holder vector after the request |

## Verification
The hardest case to reach from the ports is a data load that must invalidate some sharers but not others. This needs a line on which instruction holders and plain data sharers are mixed, and the requester itself may be flagged. The bench builds that mix before every tested request by issuing a fetch and a load from other sharers on the same line. It then sweeps every op over every line and requester. It varies when acknowledgements return, including holding all of them back until the last invalidation has gone out, so that a response raised too early would be seen.

// File: rtl/dirseq_pkg.sv
package dirseq_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_FETCH = 2'd1,
      OP_OWN   = 2'd2,
      OP_EVICT = 2'd3
   } dseq_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_INV  = 2'd1,
      ST_RESP = 2'd2
   } dseq_state_e;

endpackage

// File: rtl/dirseq_store.sv
module dirseq_store #(
   parameter int NUM_SHARERS = 64,
   parameter int NUM_LINES   = 8,
   parameter int LINEW       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LINEW-1:0]       rd_line,
   output logic [NUM_SHARERS-1:0] rd_shr,
   output logic [NUM_SHARERS-1:0] rd_ifl,
   input  logic                   wr_en,
   input  logic [LINEW-1:0]       wr_line,
   input  logic [NUM_SHARERS-1:0] wr_shr,
   input  logic [NUM_SHARERS-1:0] wr_ifl
);

   logic [NUM_SHARERS-1:0] shr_q [NUM_LINES];
   logic [NUM_SHARERS-1:0] ifl_q [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic hit;
      assign hit = wr_en && (wr_line == LINEW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shr_q[g] <= '0;
            ifl_q[g] <= '0;
         end else if (hit) begin
            shr_q[g] <= wr_shr;
            ifl_q[g] <= wr_ifl;
         end
      end
   end

   always_comb begin
      rd_shr = '0;
      rd_ifl = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (rd_line == LINEW'(i)) begin
            rd_shr = shr_q[i];
            rd_ifl = ifl_q[i];
         end
      end
   end

endmodule

// File: rtl/dirseq_policy.sv
module dirseq_policy
   import dirseq_pkg::*;
#(
   parameter int NUM_SHARERS = 64,
   parameter int IDXW        = 6
) (
   input  dseq_op_e               op,
   input  logic [IDXW-1:0]        src,
   input  logic [NUM_SHARERS-1:0] cur_shr,
   input  logic [NUM_SHARERS-1:0] cur_ifl,
   output logic [NUM_SHARERS-1:0] kill,
   output logic [NUM_SHARERS-1:0] new_shr,
   output logic [NUM_SHARERS-1:0] new_ifl
);

   localparam logic [NUM_SHARERS-1:0] ONE = NUM_SHARERS'(1);

   logic [NUM_SHARERS-1:0] self;
   assign self = ONE << src;

   always_comb begin
      unique case (op)
         OP_LOAD: begin
            kill    = cur_shr & cur_ifl;
            new_shr = (cur_shr & ~kill) | self;
            new_ifl = cur_ifl & ~kill;
         end
         OP_FETCH: begin
            kill    = '0;
            new_shr = cur_shr | self;
            new_ifl = cur_ifl | self;
         end
         OP_OWN: begin
            kill    = cur_shr & ~self;
            new_shr = self;
            new_ifl = '0;
         end
         default: begin
            kill    = cur_shr;
            new_shr = '0;
            new_ifl = '0;
         end
      endcase
   end

endmodule

// File: rtl/dirseq_lowest.sv
module dirseq_lowest #(
   parameter int WIDTH = 64,
   parameter int IDXW  = 6
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDXW-1:0]  idx,
   output logic             found
);

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IDXW'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dirseq_ackcnt.sv
module dirseq_ackcnt #(
   parameter int MAXV = 64,
   parameter int CNTW = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            dec,
   output logic [CNTW-1:0] count,
   output logic            zero
);

   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec && (cnt_q != '0)})
            2'b10:   cnt_q <= (cnt_q == CNTW'(MAXV)) ? cnt_q : cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;
   assign zero  = (cnt_q == '0);

endmodule

// File: rtl/dir_inval_seq.sv
module dir_inval_seq
   import dirseq_pkg::*;
#(
   parameter int NUM_SHARERS = 64,
   parameter int NUM_LINES   = 8,
   parameter int IDXW        = $clog2(NUM_SHARERS),
   parameter int LINEW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [1:0]             req_op,
   input  logic [LINEW-1:0]       req_line,
   input  logic [IDXW-1:0]        req_src,
   output logic                   inv_valid,
   output logic [IDXW-1:0]        inv_dst,
   output logic [LINEW-1:0]       inv_line,
   input  logic                   ack_valid,
   output logic                   rsp_valid,
   input  logic                   rsp_ready,
   output logic [1:0]             rsp_op,
   output logic [LINEW-1:0]       rsp_line,
   output logic [IDXW-1:0]        rsp_src,
   output logic [NUM_SHARERS-1:0] rsp_sharers,
   output logic [NUM_SHARERS-1:0] rsp_iflags
);

   localparam int CNTW = $clog2(NUM_SHARERS + 1);

   if (NUM_SHARERS < 2 || NUM_SHARERS > 1024) begin : g_bad_sharers
      $error("dir_inval_seq: NUM_SHARERS out of range");
   end
   if (NUM_LINES < 1 || NUM_LINES > 256) begin : g_bad_lines
      $error("dir_inval_seq: NUM_LINES out of range");
   end
   if ((1 << IDXW) < NUM_SHARERS) begin : g_bad_idxw
      $error("dir_inval_seq: IDXW too narrow");
   end

   dseq_state_e            state_q;
   dseq_op_e               op_q;
   logic [LINEW-1:0]       line_q;
   logic [IDXW-1:0]        src_q;
   logic [NUM_SHARERS-1:0] pend_q;
   logic [NUM_SHARERS-1:0] nshr_q;
   logic [NUM_SHARERS-1:0] nifl_q;

   logic [NUM_SHARERS-1:0] cur_shr, cur_ifl;
   logic [NUM_SHARERS-1:0] kill, new_shr, new_ifl;
   logic [IDXW-1:0]        pick;
   logic                   pick_ok;
   logic [CNTW-1:0]        ack_cnt;
   logic                   ack_zero;
   logic                   accept, finish;

   dirseq_store #(
      .NUM_SHARERS(NUM_SHARERS), .NUM_LINES(NUM_LINES), .LINEW(LINEW)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_line(req_line), .rd_shr(cur_shr), .rd_ifl(cur_ifl),
      .wr_en(finish), .wr_line(line_q), .wr_shr(nshr_q), .wr_ifl(nifl_q)
   );

   dirseq_policy #(
      .NUM_SHARERS(NUM_SHARERS), .IDXW(IDXW)
   ) u_policy (
      .op(dseq_op_e'(req_op)), .src(req_src),
      .cur_shr(cur_shr), .cur_ifl(cur_ifl),
      .kill(kill), .new_shr(new_shr), .new_ifl(new_ifl)
   );

   dirseq_lowest #(
      .WIDTH(NUM_SHARERS), .IDXW(IDXW)
   ) u_pick (
      .vec(pend_q), .idx(pick), .found(pick_ok)
   );

   dirseq_ackcnt #(
      .MAXV(NUM_SHARERS), .CNTW(CNTW)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(inv_valid), .dec(ack_valid),
      .count(ack_cnt), .zero(ack_zero)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign inv_valid = (state_q == ST_INV) && pick_ok;
   assign inv_dst   = pick;
   assign inv_line  = line_q;
   assign finish    = (state_q == ST_INV) && !pick_ok && ack_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_LOAD;
         line_q  <= '0;
         src_q   <= '0;
         pend_q  <= '0;
         nshr_q  <= '0;
         nifl_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_INV;
                  op_q    <= dseq_op_e'(req_op);
                  line_q  <= req_line;
                  src_q   <= req_src;
                  pend_q  <= kill;
                  nshr_q  <= new_shr;
                  nifl_q  <= new_ifl;
               end
            end
            ST_INV: begin
               if (pick_ok) begin
                  pend_q <= pend_q & ~(NUM_SHARERS'(1) << pick);
               end else if (ack_zero) begin
                  state_q <= ST_RESP;
               end
            end
            ST_RESP: begin
               if (rsp_ready) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid   = (state_q == ST_RESP);
   assign rsp_op      = op_q;
   assign rsp_line    = line_q;
   assign rsp_src     = src_q;
   assign rsp_sharers = nshr_q;
   assign rsp_iflags  = nifl_q;

endmodule

// File: rtl/dirseq_chk.sv
module dirseq_chk #(
   parameter int NUM_SHARERS = 64,
   parameter int IDXW        = 6,
   parameter int LINEW       = 3,
   parameter int CNTW        = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_ready,
   input logic                   inv_valid,
   input logic [IDXW-1:0]        inv_dst,
   input logic                   rsp_valid,
   input logic                   rsp_ready,
   input logic [1:0]             rsp_op,
   input logic [LINEW-1:0]       rsp_line,
   input logic [IDXW-1:0]        rsp_src,
   input logic [NUM_SHARERS-1:0] rsp_sharers,
   input logic [NUM_SHARERS-1:0] rsp_iflags,
   input logic [NUM_SHARERS-1:0] pend,
   input logic [CNTW-1:0]        cnt,
   input logic                   cnt_zero
);

   localparam logic [NUM_SHARERS-1:0] ONE = NUM_SHARERS'(1);

   // R2
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !inv_valid && !rsp_valid && cnt_zero);

   // R3
   inv_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && $past(inv_valid) |-> inv_dst > $past(inv_dst));

   // R3
   inv_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> pend[inv_dst]);

   // R4
   rsp_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> cnt_zero && (pend == '0));

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNTW'(NUM_SHARERS));

   // R5
   own_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_op == 2'd2) |-> (rsp_sharers == (ONE << rsp_src)) && (rsp_iflags == '0));

   // R6
   iflag_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_iflags & ~rsp_sharers) == '0);

   // R8
   evict_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_op == 2'd3) |-> (rsp_sharers == '0) && (rsp_iflags == '0));

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_sharers) && $stable(rsp_iflags)
                                  && $stable(rsp_line) && $stable(rsp_src) && $stable(rsp_op));

endmodule

bind dir_inval_seq dirseq_chk #(
   .NUM_SHARERS(NUM_SHARERS), .IDXW(IDXW), .LINEW(LINEW), .CNTW(CNTW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
   .inv_valid(inv_valid), .inv_dst(inv_dst),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
   .rsp_line(rsp_line), .rsp_src(rsp_src),
   .rsp_sharers(rsp_sharers), .rsp_iflags(rsp_iflags),
   .pend(pend_q), .cnt(ack_cnt), .cnt_zero(ack_zero)
);

// File: tb/sim_dir_inval_seq.sv
`timescale 1ns/1ps
module sim_dir_inval_seq;

   localparam int NS = 8;
   localparam int NL = 4;
   localparam int IW = 3;
   localparam int LW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [LW-1:0] req_line = '0;
   logic [IW-1:0] req_src = '0;
   logic          inv_valid;
   logic [IW-1:0] inv_dst;
   logic [LW-1:0] inv_line;
   logic          ack_valid = 1'b0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b0;
   logic [1:0]    rsp_op;
   logic [LW-1:0] rsp_line;
   logic [IW-1:0] rsp_src;
   logic [NS-1:0] rsp_sharers;
   logic [NS-1:0] rsp_iflags;

   int nvec = 0;
   int nbad = 0;
   int txn  = 0;
   logic [NS-1:0] m_shr [NL];
   logic [NS-1:0] m_ifl [NL];

   always #5 clk = ~clk;

   dir_inval_seq #(.NUM_SHARERS(NS), .NUM_LINES(NL)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_line(req_line), .req_src(req_src),
      .inv_valid(inv_valid), .inv_dst(inv_dst), .inv_line(inv_line),
      .ack_valid(ack_valid),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
      .rsp_line(rsp_line), .rsp_src(rsp_src),
      .rsp_sharers(rsp_sharers), .rsp_iflags(rsp_iflags)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_txn(input int op, input int ln, input int src, input int amode, input int rdly);
      logic [NS-1:0] self, kill, nshr, nifl, rem;
      int owed, sent, seen, nexp, cyc, want;
      bit done;
      self = NS'(1) << src;
      case (op)
         0: begin kill = m_shr[ln] & m_ifl[ln]; nshr = (m_shr[ln] & ~kill) | self; nifl = m_ifl[ln] & ~kill; end
         1: begin kill = '0; nshr = m_shr[ln] | self; nifl = m_ifl[ln] | self; end
         2: begin kill = m_shr[ln] & ~self; nshr = self; nifl = '0; end
         default: begin kill = m_shr[ln]; nshr = '0; nifl = '0; end
      endcase
      nexp = $countones(kill);
      rem  = kill;
      check(req_ready === 1'b1, "R2 ready when idle", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_op    = 2'(op);
      req_line  = LW'(ln);
      req_src   = IW'(src);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      owed = 0; sent = 0; seen = 0; cyc = 0; done = 1'b0;
      while (!done) begin
         ack_valid = 1'b0;
         if (rsp_valid === 1'b1) begin
            done = 1'b1;
            // R4: all acknowledgements delivered before the response
            check(sent == nexp && owed == 0, "R4 acks before response", 32'(sent), 32'(nexp));
            check(seen == nexp, "R3 invalidation count", 32'(seen), 32'(nexp));
            check(rsp_line == LW'(ln) && rsp_src == IW'(src) && rsp_op == 2'(op),
                  "R2 response fields", {rsp_op, 6'(rsp_line), 8'(rsp_src)}, {2'(op), 6'(ln), 8'(src)});
            if (op == 0)      check(rsp_sharers == nshr && rsp_iflags == nifl, "R6 load result", {rsp_sharers, rsp_iflags}, {nshr, nifl});
            else if (op == 1) check(rsp_sharers == nshr && rsp_iflags == nifl, "R7 fetch result", {rsp_sharers, rsp_iflags}, {nshr, nifl});
            else if (op == 2) check(rsp_sharers == nshr && rsp_iflags == nifl, "R5 store result", {rsp_sharers, rsp_iflags}, {nshr, nifl});
            else              check(rsp_sharers == nshr && rsp_iflags == nifl, "R8 evict result", {rsp_sharers, rsp_iflags}, {nshr, nifl});
         end else begin
            check(req_ready === 1'b0, "R2 no overtaking while busy", 32'(req_ready), 32'd0);
            if (owed > 0 && (amode == 0 || (amode == 1 && cyc[0]) || (amode == 2 && rem == '0))) begin
               ack_valid = 1'b1;
               owed--;
               sent++;
            end
            if (inv_valid === 1'b1) begin
               want = -1;
               for (int i = 0; i < NS; i++) if (rem[i] && want < 0) want = i;
               check(want >= 0 && inv_dst == IW'(want) && inv_line == LW'(ln),
                     "R3 invalidation order and line", {8'(inv_line), 8'(inv_dst)}, {8'(ln), 8'(want)});
               if (want >= 0) rem[want] = 1'b0;
               owed++;
               seen++;
            end
            cyc++;
            if (cyc > 400) begin
               check(1'b0, "R4 transaction watchdog", 32'(cyc), 32'd400);
               done = 1'b1;
            end
            @(negedge clk);
         end
      end
      ack_valid = 1'b0;
      for (int d = 0; d < rdly; d++) begin
         @(negedge clk);
         check(rsp_valid === 1'b1 && rsp_sharers == nshr && rsp_iflags == nifl && rsp_line == LW'(ln),
               "R9 response held", {rsp_sharers, rsp_iflags}, {nshr, nifl});
      end
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_ready = 1'b0;
      check(rsp_valid === 1'b0 && req_ready === 1'b1, "R2 back to idle", {rsp_valid, req_ready}, 2'b01);
      m_shr[ln] = nshr;
      m_ifl[ln] = nifl;
      txn++;
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin m_shr[l] = '0; m_ifl[l] = '0; end
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1 && inv_valid === 1'b0 && rsp_valid === 1'b0,
            "R1 reset outputs", {req_ready, inv_valid, rsp_valid}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty directory, so an eviction per line sends nothing
      for (int l = 0; l < NL; l++) run_txn(3, l, l, 0, 0);
      // Sweep every op over every line and requester on a mixed sharer set
      for (int l = 0; l < NL; l++) begin
         for (int s = 0; s < NS; s++) begin
            for (int op = 0; op < 4; op++) begin
               run_txn(1, l, (s + 3) % NS, txn % 3, 0);
               run_txn(0, l, (s + 5) % NS, txn % 3, 0);
               run_txn(1, l, (s + 6) % NS, txn % 3, 0);
               run_txn(op, l, s, txn % 3, txn % 2 * 2);
            end
         end
      end
      // R6: requester that holds the line as instruction is itself invalidated
      run_txn(1, 1, 2, 0, 0);
      run_txn(0, 1, 2, 2, 1);
      // R10: fill all lines differently, then evict each and compare
      for (int l = 0; l < NL; l++) begin
         for (int s = 0; s <= l + 1; s++) run_txn(s % 2, l, (s * 3 + l) % NS, 1, 0);
      end
      for (int l = 0; l < NL; l++) begin
         // R10: eviction of this line sees only its own sharers
         run_txn(3, l, 0, 2, 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #1500000;
      nvec++;
      nbad++;
      $display("FAIL R4 global watchdog expired actual=%0d expected=%0d", txn, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule